// File: doc/BRIEF.md
# Condition-Code Arithmetic Unit

This block is the arithmetic and logic stage of a small processor datapath. Each cycle it takes two operands, an operation code and an operand size (byte, word or long). It returns at once the result, cut to the chosen size. It also keeps a 4-bit condition-code register that holds negative, zero, overflow and carry flags. Each operation class has its own rule for which flags it sets, which it clears and which it keeps.

The caller fetches the operands and stores the result. The unit raises `result_we` only for operations whose result belongs in a register. Compare and the flags-only move set the flags and leave the destination untouched. Three immediate operations combine the condition-code register with a literal, so software can set, clear or flip single flags. When `op_valid` is high, the flag register loads its next value on the rising clock edge.

Top module: `cc_alu`

## Requirements
- R1: After reset, `ccr` is 0, with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R2: The size code is 0 for byte (8 bits), 1 for word (16 bits), and 2 or 3 for long (32 bits). Operand bits above the size are ignored and result bits above it read 0. For operations 0 to 10, N becomes the top bit of the sized result and Z is set when the sized result is zero.
- R3: Add (op 0) gives a+b. C is the carry out of the sized sum. V is set when a and b have the same sign and the result sign differs from that of a.
- R4: Subtract (op 1) and compare (op 2) work out a-b. C is set when a is unsigned-less than b. V is set when a and b differ in sign and the result sign differs from that of a.
- R5: When `op_valid` is high, ops 0, 1 and 3 to 9 raise `result_we`. Compare (op 2) and flags-only move (op 10) update the flags but keep `result_we` low.
- R6: Negate (op 3) gives 0-a. V is set only when a is the most negative value of the size. C is set when a is nonzero.
- R7: Increment (op 4) gives a+1 and decrement (op 5) gives a-1. V is set only when a is the largest positive value (for increment) or the most negative value (for decrement). C is unchanged.
- R8: AND (op 6), OR (op 7), XOR (op 8), move (op 9, result b) and flags-only move (op 10, result b) clear V and leave C unchanged.
- R9: Flag ops AND (op 11), OR (op 12) and XOR (op 13) combine `ccr` with `opnd_b[3:0]`; `opnd_b[7:4]` and higher are ignored. `result` is 0 and `result_we` is low.
- R10: With `op_valid` low, or with op 14 or 15, `ccr` keeps its value and `result_we` is low. Ops 14 and 15 output a `result` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle; enables the flag update |
| op_code | input | 4 | Operation code (0 to 15) |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| opnd_a | input | 32 | First operand (destination value) |
| opnd_b | input | 32 | Second operand or flag literal |
| result | output | 32 | Size-truncated result, combinational |
| result_we | output | 1 | Result should be written back |
| ccr | output | 4 | Condition-code register {N,Z,V,C} |

## Verification
The bench targets the flag edges at each size:
- **Signed overflow** (0x7F+1, 0x80-1, long 0x80000000+0x80000000). A design that takes the carry as overflow, or tests the wrong sign bit for the size, gets V wrong.
- **Negate and increment boundaries** (negating the most negative value, negating zero, incrementing 0xFF). A design that keys V off the low bits alone sets V falsely on 0xFF.
- **Flag immediates with junk in the literal's upper nibble.** A design that takes those bits would corrupt `ccr`.
- **Carry preservation across logic, move and inc/dec operations**, together with idle cycles and reserved codes. A design that writes C or drops `op_valid` gating changes flags it must keep.
- **Constrained-random mix** of operations, sizes and operand corners (0, maximum, minimum).

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_NEG  = 4'd3,
        OP_INC  = 4'd4,
        OP_DEC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_MOV  = 4'd9,
        OP_MOVF = 4'd10,
        OP_ANDC = 4'd11,
        OP_ORC  = 4'd12,
        OP_XORC = 4'd13,
        OP_RSVA = 4'd14,
        OP_RSVB = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONGX = 2'd3
    } alu_size_e;

    // bit 3 .. bit 0
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam int CCR_W = 4;

endpackage

// File: rtl/cc_size_decode.sv
module cc_size_decode
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_size_e           size_i,
    output logic [DATA_W-1:0]   mask_o,
    output logic [DATA_W-1:0]   sign_o
);
    localparam int QTR_W  = DATA_W / 4;
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        unique case (size_i)
            SZ_BYTE:  mask_o = {{(DATA_W-QTR_W){1'b0}},  {QTR_W{1'b1}}};
            SZ_WORD:  mask_o = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            SZ_LONG:  mask_o = {DATA_W{1'b1}};
            SZ_LONGX: mask_o = {DATA_W{1'b1}};
        endcase
    end

    // single bit at the top of the selected size
    assign sign_o = mask_o ^ (mask_o >> 1);

endmodule

// File: rtl/cc_alu_core.sv
module cc_alu_core
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e             op_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [DATA_W-1:0]   mask_i,
    input  logic [DATA_W-1:0]   sign_i,
    input  ccr_t                cur_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                wr_o,
    output ccr_t                nxt_o
);
    logic [DATA_W-1:0] a_m, b_m, raw;
    logic [DATA_W:0]   sum_w, dif_w;
    logic [DATA_W-1:0] sum_r, dif_r, neg_r;
    logic              sa, sb, s_sum, s_dif;
    logic              carry, borrow;
    logic              upd_nz;
    logic [CCR_W-1:0]  lit;

    assign a_m    = a_i & mask_i;
    assign b_m    = b_i & mask_i;
    assign sum_w  = {1'b0, a_m} + {1'b0, b_m};
    assign dif_w  = {1'b0, a_m} - {1'b0, b_m};
    assign sum_r  = sum_w[DATA_W-1:0] & mask_i;
    assign dif_r  = dif_w[DATA_W-1:0] & mask_i;
    assign neg_r  = (~a_m + 1'b1) & mask_i;
    assign carry  = |(sum_w & ~{1'b0, mask_i});
    assign borrow = dif_w[DATA_W];
    assign sa     = |(a_m & sign_i);
    assign sb     = |(b_m & sign_i);
    assign s_sum  = |(sum_r & sign_i);
    assign s_dif  = |(dif_r & sign_i);
    assign lit    = b_i[CCR_W-1:0];

    always_comb begin
        raw    = '0;
        wr_o   = 1'b0;
        upd_nz = 1'b0;
        nxt_o  = cur_i;
        unique case (op_i)
            OP_ADD: begin
                raw = sum_r; wr_o = 1'b1; upd_nz = 1'b1;
                nxt_o.c = carry;
                nxt_o.v = (sa == sb) && (s_sum != sa);
            end
            OP_SUB, OP_CMP: begin
                raw = dif_r; wr_o = (op_i == OP_SUB); upd_nz = 1'b1;
                nxt_o.c = borrow;
                nxt_o.v = (sa != sb) && (s_dif != sa);
            end
            OP_NEG: begin
                raw = neg_r; wr_o = 1'b1; upd_nz = 1'b1;
                nxt_o.c = (a_m != '0);
                nxt_o.v = (a_m == sign_i);
            end
            OP_INC: begin
                raw = a_m + 1'b1; wr_o = 1'b1; upd_nz = 1'b1;
                nxt_o.v = (a_m == (mask_i >> 1));
            end
            OP_DEC: begin
                raw = a_m - 1'b1; wr_o = 1'b1; upd_nz = 1'b1;
                nxt_o.v = (a_m == sign_i);
            end
            OP_AND: begin raw = a_m & b_m; wr_o = 1'b1; upd_nz = 1'b1; nxt_o.v = 1'b0; end
            OP_OR:  begin raw = a_m | b_m; wr_o = 1'b1; upd_nz = 1'b1; nxt_o.v = 1'b0; end
            OP_XOR: begin raw = a_m ^ b_m; wr_o = 1'b1; upd_nz = 1'b1; nxt_o.v = 1'b0; end
            OP_MOV: begin raw = b_m; wr_o = 1'b1; upd_nz = 1'b1; nxt_o.v = 1'b0; end
            OP_MOVF: begin raw = b_m; upd_nz = 1'b1; nxt_o.v = 1'b0; end
            OP_ANDC: nxt_o = cur_i & lit;
            OP_ORC:  nxt_o = cur_i | lit;
            OP_XORC: nxt_o = cur_i ^ lit;
            OP_RSVA, OP_RSVB: ;
        endcase
        res_o = raw & mask_i;
        if (upd_nz) begin
            nxt_o.n = |(res_o & sign_i);
            nxt_o.z = (res_o == '0);
        end
    end

endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  ccr_t d_i,
    output ccr_t q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= '0;
        else if (upd_i)
            q_o <= d_i;
    end

endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [CCR_W-1:0]  ccr
);
    logic [DATA_W-1:0] mask, sign;
    logic              wr;
    ccr_t              cur, nxt;

    cc_size_decode #(.DATA_W(DATA_W)) u_size (
        .size_i (alu_size_e'(op_size)),
        .mask_o (mask),
        .sign_o (sign)
    );

    cc_alu_core #(.DATA_W(DATA_W)) u_core (
        .op_i   (alu_op_e'(op_code)),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .mask_i (mask),
        .sign_i (sign),
        .cur_i  (cur),
        .res_o  (result),
        .wr_o   (wr),
        .nxt_o  (nxt)
    );

    cc_flag_reg u_ccr (
        .clk   (clk),
        .rst_n (rst_n),
        .upd_i (op_valid),
        .d_i   (nxt),
        .q_o   (cur)
    );

    assign result_we = op_valid && wr;
    assign ccr       = cur;

endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [1:0]        op_size,
    input logic [DATA_W-1:0] result,
    input logic              result_we,
    input logic [3:0]        ccr
);
    localparam int QTR_W = DATA_W / 4;

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(ccr));

    p_rsv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd14) |=> $stable(ccr));

    p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd2 || op_code == 4'd10)) |-> !result_we);

    p_byte_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_size == 2'd0) |-> (result[DATA_W-1:QTR_W] == '0));

    p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 4'd10) |=> (ccr[2] == ($past(result) == '0)));

    p_logic_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd6 && op_code <= 4'd10)
        |=> (!ccr[1] && ccr[0] == $past(ccr[0])));

    p_incdec_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd4 || op_code == 4'd5)) |=> (ccr[0] == $past(ccr[0])));

    p_flagop_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd11) |-> (!result_we && result == '0));

endmodule

bind cc_alu cc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_size   (op_size),
    .result    (result),
    .result_we (result_we),
    .ccr       (ccr)
);

// File: tb/sim_cc_alu.sv
`timescale 1ns/1ps
module sim_cc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  ccr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] cc_m = 4'h0;

    always #4 clk = ~clk;

    cc_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .result_we(result_we), .ccr(ccr)
    );

    // returns {we, ccr_next, result}
    function automatic logic [36:0] model_f(input logic [3:0] op, input logic [1:0] sz,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [3:0] cc, input logic vld);
        int w;
        longint one, mask, ua, ub, sa, sbv, lo, hi, r, t;
        logic n, z, v, c, we, arith;
        logic [31:0] res;
        logic [3:0] nc;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        one = 64'sd1;
        mask = (one << w) - 1;
        ua = longint'({32'b0, a}) & mask;
        ub = longint'({32'b0, b}) & mask;
        sa  = (ua >= (one << (w-1))) ? ua - (one << w) : ua;
        sbv = (ub >= (one << (w-1))) ? ub - (one << w) : ub;
        lo = -(one << (w-1));
        hi = (one << (w-1)) - 1;
        n = 1'b0; z = 1'b0; v = cc[1]; c = cc[0];
        we = 1'b0; r = 0; t = 0; arith = 1'b1; nc = cc;
        case (op)
            4'd0: begin r = ua + ub; t = sa + sbv; c = (r > mask); v = (t > hi) || (t < lo); we = 1'b1; end
            4'd1, 4'd2: begin r = ua - ub; t = sa - sbv; c = (ua < ub); v = (t > hi) || (t < lo); we = (op == 4'd1); end
            4'd3: begin r = -ua; t = -sa; c = (ua != 0); v = (t > hi); we = 1'b1; end
            4'd4: begin r = ua + 1; v = (sa + 1 > hi); we = 1'b1; end
            4'd5: begin r = ua - 1; v = (sa - 1 < lo); we = 1'b1; end
            4'd6: begin r = ua & ub; v = 1'b0; we = 1'b1; end
            4'd7: begin r = ua | ub; v = 1'b0; we = 1'b1; end
            4'd8: begin r = ua ^ ub; v = 1'b0; we = 1'b1; end
            4'd9: begin r = ub; v = 1'b0; we = 1'b1; end
            4'd10: begin r = ub; v = 1'b0; end
            4'd11: begin nc = cc & b[3:0]; arith = 1'b0; end
            4'd12: begin nc = cc | b[3:0]; arith = 1'b0; end
            4'd13: begin nc = cc ^ b[3:0]; arith = 1'b0; end
            default: arith = 1'b0;
        endcase
        res = 32'(r & mask);
        if (arith) begin
            n = res[w-1];
            z = (res == 32'd0);
            nc = {n, z, v, c};
        end
        if (!vld) begin
            nc = cc;
            we = 1'b0;
        end
        return {we, nc, res};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic vld, input logic [3:0] op,
                         input logic [1:0] sz, input logic [31:0] a, input logic [31:0] b);
        logic [36:0] m;
        @(negedge clk);
        op_valid = vld; op_code = op; op_size = sz; opnd_a = a; opnd_b = b;
        m = model_f(op, sz, a, b, cc_m, vld);
        #1;
        check({tag, " result"}, result, m[31:0]);
        check({tag, " we"}, {31'b0, result_we}, {31'b0, m[36]});
        cc_m = m[35:32];
        @(posedge clk);
        #1;
        check({tag, " ccr"}, {28'b0, ccr}, {28'b0, cc_m});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        #20;
        check("R1 reset ccr", {28'b0, ccr}, 32'd0);
        rst_n = 1'b1;
        #3;
        check("R1 ccr after release", {28'b0, ccr}, 32'd0);

        apply("R3 byte add overflow", 1, 4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001);
        apply("R3 word add carry zero", 1, 4'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001);
        apply("R3 long add V C Z", 1, 4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000);
        apply("R2 byte ignores upper", 1, 4'd0, 2'd0, 32'h1234_5601, 32'hABCD_EF02);
        apply("R4 byte sub overflow", 1, 4'd1, 2'd0, 32'h0000_0080, 32'h0000_0001);
        apply("R4 word sub borrow", 1, 4'd1, 2'd1, 32'h0000_0001, 32'h0000_0002);
        apply("R5 cmp equal no write", 1, 4'd2, 2'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        apply("R6 neg most negative", 1, 4'd3, 2'd0, 32'h0000_0080, 32'h0);
        apply("R6 neg zero", 1, 4'd3, 2'd2, 32'h0, 32'h0);
        apply("R6 long neg min", 1, 4'd3, 2'd2, 32'h8000_0000, 32'h0);
        apply("R7 word inc max", 1, 4'd4, 2'd1, 32'h0000_7FFF, 32'h0);
        apply("R7 byte inc FF no V", 1, 4'd4, 2'd0, 32'h0000_00FF, 32'h0);
        apply("R7 long dec min", 1, 4'd5, 2'd2, 32'h8000_0000, 32'h0);
        apply("R9 orc set all", 1, 4'd12, 2'd0, 32'h0, 32'h0000_000F);
        apply("R8 and keeps C", 1, 4'd6, 2'd1, 32'h0000_F0F0, 32'h0000_0F0F);
        apply("R8 mov negative", 1, 4'd9, 2'd0, 32'h0, 32'h0000_0081);
        apply("R5 movf no write", 1, 4'd10, 2'd1, 32'h1111_1111, 32'h0000_0000);
        apply("R9 andc upper ignored", 1, 4'd11, 2'd0, 32'h0, 32'h0000_00F5);
        apply("R9 xorc", 1, 4'd13, 2'd2, 32'hFFFF_FFFF, 32'h0000_00A3);
        apply("R10 idle add", 0, 4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001);
        apply("R10 reserved 14", 1, 4'd14, 2'd2, 32'h0, 32'h0);
        apply("R10 reserved 15", 1, 4'd15, 2'd0, 32'h0000_00FF, 32'h0000_0001);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            logic [3:0]  rop;
            logic [1:0]  rsz;
            ra = $urandom; rb = $urandom;
            rop = 4'($urandom % 16);
            rsz = 2'($urandom % 4);
            case ($urandom % 6)
                0: ra = 32'h0;
                1: ra = 32'h7F7F_7FFF;
                2: ra = 32'h8000_8080;
                default: ;
            endcase
            apply("R2 R3 R4 R6 R7 R8 random", ($urandom % 8) != 0, rop, rsz, ra, rb);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule